// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the configuration front end of a legacy PC peripheral-combo chip. Software reaches it through two byte-wide addresses: the even one is an index port that picks which configuration register is addressed, and the odd one is a data port that reads or writes that register. There are three configuration registers. One holds function enables, one holds function base-address selections, and one holds power and test controls. Their current values drive the downstream peripheral logic directly.

Before software has ever written the index port, reads of the index port return a short identification sequence. This lets a probe routine recognise the chip. Once the index has been written, index reads echo the selected index instead.

On reset, all three registers take default values from a 32-entry table. The entry is chosen by a 5-bit strap input that is normally tied at board level, and a strap value of 1 is the usual choice. Reads are combinational from the current state. Writes and the identification-step counter update on the clock edge.

Top module: `sio_cfg_port`

## Requirements
- R1: Address bit 0 selects the port. A value of 0 addresses the index port and a value of 1 addresses the data port. Every access is one byte.
- R2: A write to the index port stores all 8 bits of the written byte as the selected index, effective from the next cycle.
- R3: A data-port write updates a register from the next cycle when the selected index is 0, 1 or 2. Index 0 writes `fn_enable`, index 1 writes `fn_addr` and index 2 writes `pwr_test`.
- R4: A data-port write while the selected index is 3 or more changes none of the three registers.
- R5: A data-port read returns the register picked by the selected index (0, 1 or 2, mapped as in R3). If the selected index is 3 or more, it returns 0x00.
- R6: After reset, and until the index port is first written, index-port reads return three things in order. The first read returns 0x88, the second returns 0x00, and every later read returns the selected index.
- R7: After any index-port write, every index-port read returns the selected index.
- R8: Reset sets the selected index to 0 and loads the three registers from the strap-indexed table. For example, strap 1 gives enable 0x4F, address 0x11 and power 0x00, and strap 31 gives 0x00, 0x10 and 0x02.
- R9: Read data is combinational from the current state. A data-port read changes no state, so it does not advance the identification sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr0 | input | 1 | Address bit 0: 0 = index port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational |
| strap | input | 5 | Board strap that selects the reset table entry |
| fn_enable | output | 8 | Function enable register |
| fn_addr | output | 8 | Function address-select register |
| pwr_test | output | 8 | Power and test control register |

## Verification
The bench sweeps all 32 strap values through reset. For each strap it checks the three register outputs, the three data-port reads, and the identification sequence, so a wrong table entry or a wrong register-to-index mapping shows up against an arithmetic restatement of the table. It also writes every one of the 256 index values. After each one it reads the index and the data port back, then writes the data port, which separates the valid indices from the ignored ones and finds any truncation of the stored index. A data read placed before the identification reads tells a correctly idle counter apart from one that counts every read strobe.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int DATA_W   = 8;
  localparam int STRAP_W  = 5;
  localparam int NUM_REGS = 3;
  localparam int STEP_W   = 2;

  localparam logic [STEP_W-1:0] STEP_FIRST  = 2'd0;
  localparam logic [STEP_W-1:0] STEP_SECOND = 2'd1;
  localparam logic [STEP_W-1:0] STEP_DONE   = 2'd2;

  typedef struct packed {
    logic [DATA_W-1:0] pwr;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] en;
  } cfg_set_t;

  function automatic logic [DATA_W-1:0] dflt_enable(input logic [STRAP_W-1:0] s);
    logic [DATA_W-1:0] v;
    case (s)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5:        v = 8'h4F;
      5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11:      v = 8'h4B;
      5'd12, 5'd13, 5'd14, 5'd15:                v = 8'h0F;
      5'd16, 5'd17, 5'd18, 5'd19:                v = 8'h49;
      5'd20, 5'd21, 5'd22, 5'd23:                v = 8'h07;
      5'd24, 5'd25, 5'd26, 5'd27, 5'd28, 5'd29:  v = 8'h47;
      5'd30:                                     v = 8'h08;
      default:                                   v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] dflt_address(input logic [STRAP_W-1:0] s);
    logic [DATA_W-1:0] v;
    case (s)
      5'd6, 5'd16, 5'd19:                               v = 8'h00;
      5'd7, 5'd8, 5'd17, 5'd18:                         v = 8'h01;
      5'd10, 5'd11:                                     v = 8'h08;
      5'd9:                                             v = 8'h09;
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31:          v = 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:           v = 8'h11;
      5'd4, 5'd15, 5'd23, 5'd28:                        v = 8'h24;
      5'd5, 5'd29:                                      v = 8'h38;
      default:                                          v = 8'h39;
    endcase
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] dflt_power(input logic [STRAP_W-1:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  function automatic cfg_set_t strap_defaults(input logic [STRAP_W-1:0] s);
    cfg_set_t c;
    c.en   = dflt_enable(s);
    c.addr = dflt_address(s);
    c.pwr  = dflt_power(s);
    return c;
  endfunction

  function automatic logic idx_in_range(input logic [DATA_W-1:0] idx);
    return idx < DATA_W'(NUM_REGS);
  endfunction

endpackage

// File: rtl/sio_id_seq.sv
module sio_id_seq
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic              idx_rd,
  output logic [STEP_W-1:0] step_o
);

  logic [STEP_W-1:0] step_q;
  logic              step_adv;

  assign step_adv = idx_rd && (step_q < STEP_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n)        step_q <= STEP_FIRST;
    else if (idx_wr)   step_q <= STEP_DONE;
    else if (step_adv) step_q <= step_q + 1'b1;
  end

  assign step_o = step_q;

  // R7: an index write ends the identification sequence
  a_r7_wr_ends_id: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> step_o == STEP_DONE);

  // R6: the step never moves backwards outside reset
  a_r6_step_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> step_o >= $past(step_o));

  // R9: without an index access the step holds
  a_r9_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr && !idx_rd |=> $stable(step_o));

endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [STRAP_W-1:0]         strap,
  input  logic                       idx_wr,
  input  logic                       dat_wr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          sel_idx_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  localparam int IDX_SEL_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0]          sel_q;
  logic [NUM_REGS*DATA_W-1:0] rst_vals;
  logic                       dat_wr_ok;
  logic                       dat_wr_drop;
  cfg_set_t                   dflt;

  assign dflt        = strap_defaults(strap);
  assign rst_vals    = dflt;
  assign dat_wr_ok   = dat_wr && idx_in_range(sel_q);
  assign dat_wr_drop = dat_wr && !idx_in_range(sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (idx_wr) sel_q <= wr_data;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    logic              hit;
    assign hit = dat_wr_ok && (sel_q[IDX_SEL_W-1:0] == IDX_SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   r_q <= rst_vals[g*DATA_W +: DATA_W];
      else if (hit) r_q <= wr_data;
    end
    assign regs_o[g*DATA_W +: DATA_W] = r_q;
  end

  assign sel_idx_o = sel_q;

  // R2: index write captures the full byte
  a_r2_idx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> sel_idx_o == $past(wr_data));

  // R4: out-of-range data writes leave every register alone
  a_r4_drop_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_drop |=> $stable(regs_o));

  // R3: registers change only through an accepted data write
  a_r3_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr_ok |=> $stable(regs_o));

endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_BYTE = 8'h88,
  parameter logic [DATA_W-1:0] ID_FILL = 8'h00
) (
  input  logic                       addr0,
  input  logic [STEP_W-1:0]          step,
  input  logic [DATA_W-1:0]          sel_idx,
  input  logic [NUM_REGS*DATA_W-1:0] regs,
  output logic [DATA_W-1:0]          rd_data
);

  logic [DATA_W-1:0] idx_val;
  logic [DATA_W-1:0] dat_val;

  always_comb begin
    case (step)
      STEP_FIRST:  idx_val = ID_BYTE;
      STEP_SECOND: idx_val = ID_FILL;
      default:     idx_val = sel_idx;
    endcase
  end

  always_comb begin
    dat_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel_idx == DATA_W'(i)) dat_val = regs[i*DATA_W +: DATA_W];
    end
  end

  assign rd_data = addr0 ? dat_val : idx_val;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr0,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  input  logic [4:0]         strap,
  output logic [7:0]         fn_enable,
  output logic [7:0]         fn_addr,
  output logic [7:0]         pwr_test
);

  logic                       idx_wr;
  logic                       idx_rd;
  logic                       dat_wr;
  logic [STEP_W-1:0]          step;
  logic [DATA_W-1:0]          sel_idx;
  logic [NUM_REGS*DATA_W-1:0] regs;

  assign idx_wr = wr_en && !addr0;
  assign idx_rd = rd_en && !addr0;
  assign dat_wr = wr_en && addr0;

  sio_id_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .idx_rd (idx_rd),
    .step_o (step)
  );

  sio_cfg_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap),
    .idx_wr    (idx_wr),
    .dat_wr    (dat_wr),
    .wr_data   (wr_data),
    .sel_idx_o (sel_idx),
    .regs_o    (regs)
  );

  sio_rd_mux u_mux (
    .addr0   (addr0),
    .step    (step),
    .sel_idx (sel_idx),
    .regs    (regs),
    .rd_data (rd_data)
  );

  assign fn_enable = regs[0*DATA_W +: DATA_W];
  assign fn_addr   = regs[1*DATA_W +: DATA_W];
  assign pwr_test  = regs[2*DATA_W +: DATA_W];

  // R5: data reads at an out-of-range index return zero
  a_r5_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr0 && !idx_in_range(sel_idx) |-> rd_data == 8'h00);

  // R3: data reads at index 0 reflect the enable register
  a_r3_read_enable: assert property (@(posedge clk) disable iff (!rst_n)
    addr0 && sel_idx == 8'd0 |-> rd_data == fn_enable);

  // R7: once the sequence is done, index reads echo the index
  a_r7_idx_echo: assert property (@(posedge clk) disable iff (!rst_n)
    !addr0 && step == STEP_DONE |-> rd_data == sel_idx);

endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr0 = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [4:0] strap = 5'd1;
  logic [7:0] fn_enable, fn_addr, pwr_test;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .addr0(addr0), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .strap(strap),
    .fn_enable(fn_enable), .fn_addr(fn_addr), .pwr_test(pwr_test)
  );

  localparam logic [7:0] ADDR_TBL [32] = '{
    8'h10, 8'h11, 8'h11, 8'h39, 8'h24, 8'h38, 8'h00, 8'h01,
    8'h01, 8'h09, 8'h08, 8'h08, 8'h10, 8'h11, 8'h39, 8'h24,
    8'h00, 8'h01, 8'h01, 8'h00, 8'h10, 8'h11, 8'h39, 8'h24,
    8'h10, 8'h11, 8'h11, 8'h39, 8'h24, 8'h38, 8'h10, 8'h10};

  function automatic logic [7:0] exp_en(input int s);
    if (s < 6)  return 8'h4F;
    if (s < 12) return 8'h4B;
    if (s < 16) return 8'h0F;
    if (s < 20) return 8'h49;
    if (s < 24) return 8'h07;
    if (s < 30) return 8'h47;
    if (s == 30) return 8'h08;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_pwr(input int s);
    return (s == 31) ? 8'h02 : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr0 = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr0 = a; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] e0, e1, e2;
    // R8 / R6 / R5 / R9: every strap value
    for (int s = 0; s < 32; s++) begin
      do_reset(5'(s));
      check("R8 enable reset", fn_enable, exp_en(s));
      check("R8 address reset", fn_addr, ADDR_TBL[s]);
      check("R8 power reset", pwr_test, exp_pwr(s));
      // R9: data read before any index read leaves the sequence at its start
      do_read(1'b1, v); check("R9 R5 R8 data read idx0", v, exp_en(s));
      do_read(1'b0, v); check("R6 first id byte", v, 8'h88);
      do_read(1'b0, v); check("R6 second id byte", v, 8'h00);
      do_read(1'b0, v); check("R6 R8 index echo 0", v, 8'h00);
      do_read(1'b0, v); check("R6 index echo stays", v, 8'h00);
      do_write(1'b0, 8'd1);
      do_read(1'b1, v); check("R5 R1 data read idx1", v, ADDR_TBL[s]);
      do_write(1'b0, 8'd2);
      do_read(1'b1, v); check("R5 data read idx2", v, exp_pwr(s));
    end

    // R7: index write before any index read ends the sequence immediately
    do_reset(5'd1);
    do_write(1'b0, 8'h02);
    do_read(1'b0, v); check("R7 echo after early write", v, 8'h02);

    // R3: writes through each valid index
    do_reset(5'd1);
    for (int i = 0; i < 3; i++) begin
      do_write(1'b0, 8'(i));
      do_write(1'b1, 8'hA0 + 8'(i));
    end
    check("R3 enable written", fn_enable, 8'hA0);
    check("R3 address written", fn_addr, 8'hA1);
    check("R3 power written", pwr_test, 8'hA2);
    e0 = 8'hA0; e1 = 8'hA1; e2 = 8'hA2;

    // R2 / R4 / R5 / R7: sweep every index value
    for (int k = 0; k < 256; k++) begin
      logic [7:0] d;
      d = 8'(k) ^ 8'h5A;
      do_write(1'b0, 8'(k));
      do_read(1'b0, v); check("R2 R7 index readback", v, 8'(k));
      do_read(1'b1, v);
      if (k == 0)      check("R5 read idx0", v, e0);
      else if (k == 1) check("R5 read idx1", v, e1);
      else if (k == 2) check("R5 read idx2", v, e2);
      else             check("R5 oob read zero", v, 8'h00);
      do_write(1'b1, d);
      if (k == 0) e0 = d;
      if (k == 1) e1 = d;
      if (k == 2) e2 = d;
      check("R3 R4 enable after write", fn_enable, e0);
      check("R3 R4 address after write", fn_addr, e1);
      check("R3 R4 power after write", pwr_test, e2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule